// File: doc/BRIEF.md
# Dual-channel high/low count PWM

This block generates two independent pulse-width-modulated outputs. Each channel is described by two 16-bit lengths: the number of counts its output stays high and the number of counts it then stays low. The pair repeats without end. The length of one count comes from a per-channel prescaler. The prescaler takes one of four source tick-enable inputs, all in the single clock domain, and divides it by a programmable factor.

Software programs the block through a three-word register bank. There is one count word per channel, and both channels share one control word. In the control word each channel has an output enable, a count enable, a 7-bit divider and a 2-bit source select. A channel runs only while both of its enables are set. Clearing the output enable drives the output low at once, without waiting for the period to end. A new count word is applied at the next period boundary, so changing the duty never produces a truncated pulse.

Each channel is a small state machine with three states. CH_IDLE holds the output low while the channel is gated off. CH_HIGH counts the high length. CH_LOW counts the low length. The transitions are:
- ENABLE (CH_IDLE to CH_HIGH, or to CH_LOW if the high length is zero), which loads the count word.
- HIGH_DONE (CH_HIGH to CH_LOW).
- BOUNDARY (CH_LOW to CH_HIGH or CH_LOW, which reloads the count word).
- GATE_OFF (any state to CH_IDLE when either enable is clear).

Top module: `twin_span_pwm`

## Requirements
- R1: Channel A's count word is at byte offset 0x0, channel B's count word at 0x4 and the control word at 0x8. A read of any of these returns the last 32-bit value written there. All three reset to zero. A read of any other offset returns zero, and a write to any other offset is ignored.
- R2: In a count word, bits 31:16 are the high length and bits 15:0 are the low length. The output is high for the high length in counts, then low for the low length in counts, and the cycle repeats.
- R3: In the control word, bit 0 is channel A's output enable and bit 1 is channel B's. Bit 15 is channel A's count enable and bit 23 is channel B's. A channel runs only while both of its bits are 1. Otherwise its output is low.
- R4: Each channel has a divider value d, at bits 14:8 for A and bits 22:16 for B. One count lasts d+1 ticks of the selected source.
- R5: Each channel has a source select s, at bits 5:4 for A and bits 7:6 for B. It picks src_tick[s] as the tick that the channel's prescaler counts.
- R6: A write that clears a channel's output enable makes that output low from the clock edge that performs the write. There is no wait for the end of the period.
- R7: A high length of zero gives a constant-low output.
- R8: A low length of zero gives a low phase of one count. With high length 0xFFFF and low length 0, the output is high for 65535 counts and low for 1 count.
- R9: When a channel becomes enabled, it loads its count word at the next clock edge. If the high length is nonzero, it starts a fresh high phase at that edge.
- R10: A count word written while a channel runs does not change the period in progress. It takes effect from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Four tick-enable sources, one clock domain |
| pwm_out | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
Run lengths are measured at the output in steady state and compared with length × (d+1) × source period.

- Directed patterns cover several combinations:
  - distinct high and low lengths on one source.
  - a source ticking every third cycle with a divider, which separates divider errors from source-select errors.
  - a source that never ticks, which shows that the selected input alone paces the count.
  - both channels running at once, which exposes any crosstalk through the shared control word.
- Random lengths, dividers and sources on a random channel check the product rule across many combinations.
- Dedicated cases cover:
  - zero high length and zero low length.
  - the full 0xFFFF high length.
  - a count word rewritten in mid-period, which tells immediate loading apart from boundary loading.
  - disable in mid-high phase, which tells an immediate stop apart from finishing the period.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 7;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 1 << SEL_W;
    localparam int N_CH   = 2;
    localparam int N_REG  = N_CH + 1;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic             out_en;
        logic             cnt_en;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
    } ch_cfg_t;

    // Control word bit positions, per channel index.
    function automatic int en_bit(input int ch);
        return ch;
    endfunction

    function automatic int cnt_en_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction
endpackage

// File: rtl/tsp_regbank.sv
module tsp_regbank
    import tsp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [N_CH-1:0][DATA_W-1:0]   cnt_word,
    output logic [DATA_W-1:0]             ctrl_word
);
    localparam int IDX_W = ADDR_W - 2;

    logic [N_REG-1:0][DATA_W-1:0] regs_q;
    logic [IDX_W-1:0]             idx;
    logic                         hit;

    assign idx = bus_addr[ADDR_W-1:2];
    assign hit = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(N_REG));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (bus_wr && hit) begin
            regs_q[idx] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata = regs_q[idx];
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_cnt
            assign cnt_word[g] = regs_q[g];
        end
    endgenerate

    assign ctrl_word = regs_q[N_CH];
endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler
    import tsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic             hold,
    output logic             count_tick
);
    logic [DIV_W-1:0] div_cnt_q;
    logic             tick_sel;
    logic             wrap;

    assign tick_sel   = src_tick[sel];
    assign wrap       = (div_cnt_q == div);
    assign count_tick = tick_sel && wrap && !hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
        end else if (hold) begin
            div_cnt_q <= '0;
        end else if (tick_sel) begin
            div_cnt_q <= wrap ? '0 : div_cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tsp_channel.sv
module tsp_channel
    import tsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             count_tick,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             pwm,
    output logic             idle,
    output logic [CNT_W-1:0] live_hi
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_q, hi_d;
    logic [CNT_W-1:0] lo_q, lo_d;
    logic [CNT_W-1:0] lo_last;

    // A zero low length still spends one count low.
    assign lo_last = (lo_q == '0) ? '0 : lo_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        if (!active) begin
            // GATE_OFF
            state_d = CH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    // ENABLE
                    hi_d    = hi_in;
                    lo_d    = lo_in;
                    cnt_d   = '0;
                    state_d = (hi_in != '0) ? CH_HIGH : CH_LOW;
                end
                CH_HIGH: begin
                    if (count_tick) begin
                        if (cnt_q == hi_q - CNT_W'(1)) begin
                            // HIGH_DONE
                            cnt_d   = '0;
                            state_d = CH_LOW;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                CH_LOW: begin
                    if (count_tick) begin
                        if (cnt_q == lo_last) begin
                            // BOUNDARY
                            hi_d    = hi_in;
                            lo_d    = lo_in;
                            cnt_d   = '0;
                            state_d = (hi_in != '0) ? CH_HIGH : CH_LOW;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        pwm     = active && (state_q == CH_HIGH);
        idle    = (state_q == CH_IDLE);
        live_hi = hi_q;
    end
endmodule

// File: rtl/twin_span_pwm.sv
module twin_span_pwm
    import tsp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_tick,
    output logic [N_CH-1:0]   pwm_out
);
    logic [N_CH-1:0][DATA_W-1:0] cnt_word;
    logic [DATA_W-1:0]           ctrl_word;
    logic [N_CH-1:0]             ch_active;
    logic [N_CH-1:0][CNT_W-1:0]  live_hi;

    tsp_regbank #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_word  (cnt_word),
        .ctrl_word (ctrl_word)
    );

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_ch
            localparam int EB = en_bit(g);
            localparam int CB = cnt_en_bit(g);
            localparam int DL = div_lsb(g);
            localparam int SL = sel_lsb(g);

            ch_cfg_t cfg;
            logic    count_tick;
            logic    idle;
            logic    ch_pwm;
            logic [CNT_W-1:0] ch_live_hi;

            assign cfg.out_en = ctrl_word[EB];
            assign cfg.cnt_en = ctrl_word[CB];
            assign cfg.div    = ctrl_word[DL +: DIV_W];
            assign cfg.sel    = ctrl_word[SL +: SEL_W];
            assign ch_active[g] = cfg.out_en && cfg.cnt_en;

            tsp_prescaler u_pre (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_tick   (src_tick),
                .sel        (cfg.sel),
                .div        (cfg.div),
                .hold       (idle || !ch_active[g]),
                .count_tick (count_tick)
            );

            tsp_channel u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .active     (ch_active[g]),
                .count_tick (count_tick),
                .hi_in      (cnt_word[g][DATA_W-1 -: CNT_W]),
                .lo_in      (cnt_word[g][CNT_W-1:0]),
                .pwm        (ch_pwm),
                .idle       (idle),
                .live_hi    (ch_live_hi)
            );

            assign pwm_out[g] = ch_pwm;
            assign live_hi[g] = ch_live_hi;
        end
    endgenerate
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker
    import tsp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_wr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            ctrl_word,
    input logic [N_CH-1:0][DATA_W-1:0]  cnt_word,
    input logic [N_CH-1:0]              ch_active,
    input logic [N_CH-1:0][CNT_W-1:0]   live_hi,
    input logic [N_CH-1:0]              pwm_out
);
    localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(4 * N_CH);

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFF) |=> (ctrl_word == $past(bus_wdata))); // R1

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_chk
            localparam int EB = en_bit(g);
            localparam int CB = cnt_en_bit(g);

            AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !(ctrl_word[EB] && ctrl_word[CB]) |-> !pwm_out[g]); // R3

            AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == CTRL_OFF && !bus_wdata[EB]) |=> !pwm_out[g]); // R6

            AST_ZERO_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (live_hi[g] == '0) |-> !pwm_out[g]); // R7

            AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(ch_active[g]) && cnt_word[g][DATA_W-1 -: CNT_W] != '0)
                |=> (!ch_active[g] || pwm_out[g])); // R9
        end
    endgenerate
endmodule

bind twin_span_pwm tsp_checker #(.ADDR_W(ADDR_W)) u_tsp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ctrl_word (ctrl_word),
    .cnt_word  (cnt_word),
    .ch_active (ch_active),
    .live_hi   (live_hi),
    .pwm_out   (pwm_out)
);

// File: tb/twin_span_pwm_bench.sv
module twin_span_pwm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = 4'b0001;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    twin_span_pwm u_twin_span_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    // Source 0 every cycle, 1 every third, 2 every second, 3 never.
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            phase = phase + 1;
            src_tick[0] = 1'b1;
            src_tick[1] = (phase % 3 == 0);
            src_tick[2] = (phase % 2 == 0);
            src_tick[3] = 1'b0;
        end
    end

    function automatic int src_period(input int s);
        return (s == 1) ? 3 : (s == 2) ? 2 : 1;
    endfunction

    function automatic logic [31:0] ctrl_of(input bit ena, input bit cea, input int da, input int sa,
                                            input bit enb, input bit ceb, input int db, input int sb);
        logic [31:0] w = '0;
        w[0] = ena;  w[15] = cea;  w[14:8]  = 7'(da);  w[5:4] = 2'(sa);
        w[1] = enb;  w[23] = ceb;  w[22:16] = 7'(db);  w[7:6] = 2'(sb);
        return w;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Waits at negedges for a high sample followed by a low sample.
    task automatic wait_fall(input int ch);
        int guard = 0;
        while (pwm_out[ch] !== 1'b1 && guard < 70000) begin @(negedge clk); guard++; end
        while (pwm_out[ch] !== 1'b0 && guard < 140000) begin @(negedge clk); guard++; end
    endtask

    task automatic wait_rise(input int ch);
        int guard = 0;
        while (pwm_out[ch] !== 1'b1 && guard < 70000) begin @(negedge clk); guard++; end
    endtask

    // Starting on a sample with level lvl (already counted as 1), count the run.
    task automatic run_len(input int ch, input bit lvl, output int len);
        len = 1;
        forever begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl || len > 70000) break;
            len++;
        end
    endtask

    task automatic measure(input int ch, output int hl, output int ll);
        wait_fall(ch);
        wait_rise(ch);
        run_len(ch, 1'b1, hl);
        run_len(ch, 1'b0, ll);
    endtask

    task automatic stay_level(input string req, input int ch, input bit lvl, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) bad++;
        end
        check(req, "cycles off the held level", bad, 0);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] v;
        int hl, ll, ch, hi, lo, d, s, p;
        void'($urandom(32'd2024));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "reset pwm_out", pwm_out, 0);
        bus_read(4'h0, rd); check("R1", "reset word 0x0", rd, 0);
        bus_read(4'h8, rd); check("R1", "reset word 0x8", rd, 0);

        // R1: random readback of all three words and an unmapped offset
        for (int i = 0; i < 3; i++) begin
            for (int a = 0; a < 3; a++) begin
                v = $urandom();
                if (a == 2) v = v & ~32'h0080_8003; // keep channels gated off
                bus_write(4'(4 * a), v);
                bus_read(4'(4 * a), rd);
                check("R1", $sformatf("readback offset %0d", 4 * a), rd, v);
            end
        end
        bus_write(4'hC, 32'hDEAD_BEEF);
        bus_read(4'hC, rd); check("R1", "unmapped offset 0xC", rd, 0);
        bus_read(4'h2, rd); check("R1", "unaligned offset 0x2", rd, 0);
        bus_write(4'h8, 32'h0);

        // R2: hi=3 lo=5, source 0, d=0
        bus_write(4'h0, {16'd3, 16'd5});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, hl, ll);
        check("R2", "A high run", hl, 3);
        check("R2", "A low run", ll, 5);

        // R4 R5: channel B, source 1 (every 3rd cycle), d=1
        bus_write(4'h4, {16'd2, 16'd3});
        bus_write(4'h8, ctrl_of(0, 0, 0, 0, 1, 1, 1, 1));
        measure(1, hl, ll);
        check("R4", "B high run with divider", hl, 2 * 2 * 3);
        check("R5", "B low run on source 1", ll, 3 * 2 * 3);

        // R5: source 3 never ticks, so a started high phase never ends
        bus_write(4'h8, 32'h0);
        bus_write(4'h8, ctrl_of(0, 0, 0, 0, 1, 1, 0, 3));
        @(negedge clk);
        stay_level("R5", 1, 1'b1, 100);
        bus_write(4'h8, 32'h0);

        // R2 R4 R5: random lengths, dividers and sources
        for (int i = 0; i < 8; i++) begin
            ch = $urandom_range(1, 0);
            hi = $urandom_range(12, 1);
            lo = $urandom_range(12, 0);
            d  = $urandom_range(3, 0);
            s  = $urandom_range(2, 0);
            p  = src_period(s);
            bus_write(4'(4 * ch), {16'(hi), 16'(lo)});
            if (ch == 0) bus_write(4'h8, ctrl_of(1, 1, d, s, 0, 0, 0, 0));
            else         bus_write(4'h8, ctrl_of(0, 0, 0, 0, 1, 1, d, s));
            measure(ch, hl, ll);
            check("R4", $sformatf("random ch%0d high hi=%0d d=%0d s=%0d", ch, hi, d, s), hl, hi * (d + 1) * p);
            check("R2", $sformatf("random ch%0d low lo=%0d d=%0d s=%0d", ch, lo, d, s), ll, ((lo == 0) ? 1 : lo) * (d + 1) * p);
            bus_write(4'h8, 32'h0);
        end

        // Both channels at once
        bus_write(4'h0, {16'd3, 16'd2});
        bus_write(4'h4, {16'd5, 16'd7});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 1, 1, 0, 2));
        measure(0, hl, ll);
        check("R3", "A high with B running", hl, 3);
        check("R3", "A low with B running", ll, 2);
        measure(1, hl, ll);
        check("R3", "B high with A running", hl, 10);
        check("R3", "B low with A running", ll, 14);
        bus_write(4'h8, 32'h0);

        // R3: output enable set but count enable clear
        bus_write(4'h0, {16'd3, 16'd3});
        bus_write(4'h8, ctrl_of(1, 0, 0, 0, 0, 0, 0, 0));
        stay_level("R3", 0, 1'b0, 60);
        bus_write(4'h8, 32'h0);

        // R7: zero high length
        bus_write(4'h0, {16'd0, 16'd5});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 0, 0, 0, 0));
        stay_level("R7", 0, 1'b0, 100);
        bus_write(4'h8, 32'h0);

        // R8: zero low length gives one low count
        bus_write(4'h0, {16'd20, 16'd0});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, hl, ll);
        check("R8", "high run with lo=0", hl, 20);
        check("R8", "low run with lo=0", ll, 1);
        bus_write(4'h8, 32'h0);

        // R9 R8: enabling starts a fresh high phase; full-length high
        bus_write(4'h0, {16'hFFFF, 16'd0});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 0, 0, 0, 0));
        check("R9", "output right after enabling write", pwm_out[0], 0);
        @(negedge clk);
        check("R9", "output one cycle after enable", pwm_out[0], 1);
        run_len(0, 1'b1, hl);
        run_len(0, 1'b0, ll);
        check("R8", "max high run", hl, 65535);
        check("R8", "low run after max high", ll, 1);
        bus_write(4'h8, 32'h0);

        // R10: rewrite count word in mid-high phase
        bus_write(4'h0, {16'd4, 16'd4});
        bus_write(4'h8, ctrl_of(1, 1, 0, 0, 0, 0, 0, 0));
        wait_fall(0);
        wait_rise(0);
        bus_addr = 4'h0; bus_wdata = {16'd8, 16'd2}; bus_wr = 1'b1;
        hl = 1;
        forever begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (pwm_out[0] !== 1'b1 || hl > 1000) break;
            hl++;
        end
        run_len(0, 1'b0, ll);
        check("R10", "high in progress keeps old length", hl, 4);
        check("R10", "low in progress keeps old length", ll, 4);
        run_len(0, 1'b1, hl);
        run_len(0, 1'b0, ll);
        check("R10", "next high uses new length", hl, 8);
        check("R10", "next low uses new length", ll, 2);

        // R6: disable in mid-high phase
        bus_write(4'h0, {16'd50, 16'd50});
        wait_fall(0);
        wait_rise(0);
        repeat (5) @(negedge clk);
        check("R6", "high before disable", pwm_out[0], 1);
        bus_write(4'h8, ctrl_of(0, 1, 0, 0, 0, 0, 0, 0));
        check("R6", "low right after disabling write", pwm_out[0], 0);
        stay_level("R6", 0, 1'b0, 100);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule